// File: doc/BRIEF.md
# Synchronous Single-Word Read Master

This block fetches one word at a time from a memory on a synchronous bus that has separate address lines, a read strobe and data lines. A requester presents an address together with a start strobe. When the block is free, it takes the address, drives it onto the bus, waits a fixed number of setup cycles and then raises the read strobe. It holds the strobe for a fixed access latency and samples the data lines on the clock edge that ends that window. It then drops the strobe and returns the sampled word with a one-cycle done pulse. A recovery window follows during which no new read may begin, because the memory may still be driving the data lines.

The controller has four states. In IDLE it is ready. A start while ready takes the path IDLE to SETUP and latches the address. SETUP to ACCESS is taken after SETUP_CYC cycles and raises the strobe. ACCESS to RECOVER is taken after ACCESS_CYC cycles; the data word is captured and the strobe dropped on that edge. RECOVER to IDLE is taken after RECOVER_CYC cycles. A start presented while the block is not in IDLE is not lost. The requester keeps it asserted, and the block accepts it on the first cycle that ready is high. All three delay parameters must be at least 1. Their defaults are 1, 4 and 2. The default data word is 32 bits (4 bytes).

Top module: `sync_rd_master`

## Requirements
- R1: While synchronous reset is applied, and in the cycle after it is applied, bus_rd and rsp_done are 0 and req_ready is 1.
- R2: req_ready is 1 exactly when the block is idle. A start is accepted on a clock edge where req_valid and req_ready are both 1, and only then.
- R3: From the cycle after acceptance until the strobe falls, bus_addr equals the address presented at acceptance, even if req_addr changes meanwhile.
- R4: bus_rd is 0 for SETUP_CYC cycles after acceptance and then 1 for exactly ACCESS_CYC consecutive cycles.
- R5: The returned word equals the value on bus_data during the last cycle in which bus_rd is 1.
- R6: rsp_done is 1 for exactly one cycle, the first cycle after bus_rd falls, and rsp_data holds the returned word in that cycle. It is 0 at all other times.
- R7: After bus_rd falls, req_ready and bus_rd stay 0 for RECOVER_CYC cycles. req_ready then returns to 1.
- R8: A start held asserted while the block is busy is accepted on the first ready cycle, with no idle cycle in between. Every start the requester holds is accepted exactly once.
- R9: A reset applied during a read abandons it. No rsp_done follows for that read, and the block is idle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start strobe, held until accepted |
| req_addr | input | ADDR_W | Address to read |
| req_ready | output | 1 | Block is idle and accepts a start |
| rsp_done | output | 1 | One-cycle pulse marking a returned word |
| rsp_data | output | DATA_W | Returned word |
| bus_addr | output | ADDR_W | Address lines to memory |
| bus_rd | output | 1 | Read strobe to memory |
| bus_data | input | DATA_W | Data lines from memory |

## Verification
The embedded assertions check the local rules on every cycle. The strobe may rise only out of SETUP. The address must stay stable while the strobe is high. Ready and the strobe are never high together. The done pulse lasts one cycle and coincides with the strobe's fall. Ready stays low through RECOVER.

The exact cycle counts between acceptance, strobe rise, capture and ready can only be shown by the bench's scenarios. So can the correctness of the returned word and the holding of starts made while busy. The bench's memory model puts a wrong value on the data lines outside the last strobe cycle, so sampling one cycle early or late shows up as a data mismatch. The bench sweeps idle gaps between reads, starts made while busy, and a reset during a read.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_ACCESS  = 2'd2,
        ST_RECOVER = 2'd3
    } srm_state_e;

    function automatic int srm_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/srm_phase_timer.sv
// Counts cycles spent in the current phase; cleared on every phase change.
module srm_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/srm_word_reg.sv
// Loadable holding register used for the address latch and the data capture.
module srm_word_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/sync_rd_master.sv
module sync_rd_master
    import srm_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int SETUP_CYC   = 1,
    parameter int ACCESS_CYC  = 4,
    parameter int RECOVER_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_data
);
    localparam int MAXC = srm_max3(SETUP_CYC, ACCESS_CYC, RECOVER_CYC);
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] SETUP_LAST   = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] ACCESS_LAST  = CW'(ACCESS_CYC - 1);
    localparam logic [CW-1:0] RECOVER_LAST = CW'(RECOVER_CYC - 1);

    srm_state_e    state_q, state_n;
    logic [CW-1:0] ph_cnt;
    logic          ph_clr;
    logic          take_req;
    logic          capture;
    logic          done_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)              state_n = ST_SETUP;
            ST_SETUP:   if (ph_cnt == SETUP_LAST)   state_n = ST_ACCESS;
            ST_ACCESS:  if (ph_cnt == ACCESS_LAST)  state_n = ST_RECOVER;
            ST_RECOVER: if (ph_cnt == RECOVER_LAST) state_n = ST_IDLE;
            default:                                state_n = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        bus_rd    = (state_q == ST_ACCESS);
        take_req  = (state_q == ST_IDLE) && req_valid;
        capture   = (state_q == ST_ACCESS) && (ph_cnt == ACCESS_LAST);
        ph_clr    = (state_n != state_q);
    end

    srm_phase_timer #(.CW(CW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (ph_clr),
        .cnt (ph_cnt)
    );

    srm_word_reg #(.W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (take_req),
        .din  (req_addr),
        .dout (bus_addr)
    );

    srm_word_reg #(.W(DATA_W)) u_data (
        .clk  (clk),
        .rst  (rst),
        .load (capture),
        .din  (bus_data),
        .dout (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= capture;
    end
    assign rsp_done = done_q;

    // R4
    rd_rise_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |-> $past(state_q) == ST_SETUP);
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && $past(bus_rd)) |-> $stable(bus_addr));
    // R2
    ready_excl_rd_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_rd);
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    // R6
    done_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $fell(bus_rd));
    // R7
    recover_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECOVER) |-> (!req_ready && !bus_rd));

    initial begin
        assert (SETUP_CYC >= 1 && ACCESS_CYC >= 1 && RECOVER_CYC >= 1)
            else $error("delay parameters must be at least 1");
    end
endmodule

// File: tb/sync_rd_master_tb.sv
module sync_rd_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int S  = 1;
    localparam int A  = 4;
    localparam int R  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rsp_done, bus_rd;
    logic [DW-1:0] rsp_data, bus_data;
    logic [AW-1:0] bus_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_rd_master #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S),
                     .ACCESS_CYC(A), .RECOVER_CYC(R)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_data(bus_data)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, ~a};
    endfunction

    // behavioural memory: valid word only in the A-th cycle of the strobe
    int rcnt = 0;
    always @(posedge clk) rcnt <= bus_rd ? rcnt + 1 : 0;
    assign bus_data = (bus_rd && rcnt == A - 1) ? mem_word(bus_addr) : 32'hBAD0_BAD0;

    int  total = 0, fails = 0;
    int  sends = 0, accepts = 0, dones = 0;
    bit  finished = 0;
    logic rst_prev = 1'b1;
    always @(posedge clk) rst_prev <= rst;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    int cyc = 0, acc_cyc = 0;
    bit pending = 0;
    logic [AW-1:0] acc_addr;
    always @(negedge clk) begin
        int rel;
        cyc++;
        if (rst_prev) begin
            chk(bus_rd == 0,    "R1 bus_rd in reset",    bus_rd, 0);
            chk(rsp_done == 0,  "R1/R9 done in reset",   rsp_done, 0);
            chk(req_ready == 1, "R1 ready in reset",     req_ready, 1);
            pending = 0;
        end else if (!rst) begin
            if (pending) begin
                rel = cyc - acc_cyc;
                chk(bus_rd == (rel >= 1 + S && rel <= S + A), "R4 strobe window",
                    bus_rd, (rel >= 1 + S && rel <= S + A));
                if (rel <= S + A)
                    chk(bus_addr == acc_addr, "R3 address held", bus_addr, acc_addr);
                chk(rsp_done == (rel == S + A + 1), "R6 done timing",
                    rsp_done, (rel == S + A + 1));
                if (rel == S + A + 1) begin
                    chk(rsp_data == mem_word(acc_addr), "R5 returned word",
                        rsp_data, mem_word(acc_addr));
                    dones++;
                end
                chk(req_ready == (rel >= S + A + R + 1), "R7 recovery/ready",
                    req_ready, (rel >= S + A + R + 1));
                if (rel >= S + A + R + 1) pending = 0;
            end else begin
                chk(req_ready == 1, "R2 ready when idle", req_ready, 1);
                chk(bus_rd == 0,    "R2 no strobe when idle", bus_rd, 0);
                chk(rsp_done == 0,  "R9 no stray done", rsp_done, 0);
            end
        end
        if (!rst && !pending && req_valid && req_ready) begin
            pending  = 1;
            acc_cyc  = cyc;
            acc_addr = req_addr;
            accepts++;
        end
    end

    // caller enters just after a rising edge
    task automatic send(input logic [AW-1:0] a);
        req_valid = 1'b1;
        req_addr  = a;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_addr  = ~a;
        sends++;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        // sweep: idle gap 0 means the next start is held during busy (R8)
        for (int i = 0; i < 24; i++) begin
            send(AW'(i * 16'h0913 + 7));
            if (i % 4 != 0) begin
                do @(negedge clk); while (!req_ready);
                @(posedge clk); #1;
                repeat (i % 4 - 1) @(posedge clk);
                #1;
            end
        end
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        // R9: reset during the strobe window
        send(16'hBEEF);
        repeat (3) @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) send(AW'(16'hF000 + i));
        repeat (12) @(posedge clk);
        #1;
        // R8: every held start accepted once
        chk(accepts == sends, "R8 accept count", accepts, sends);
        // R9: aborted read produced no done
        chk(dones == sends - 1, "R9 done count", dones, sends - 1);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end
endmodule